// File: doc/BRIEF.md
# Sequential Add-Shift Multiplier

This block multiplies two `W`-bit operands over `W` clock steps. It uses one adder that is `W+1` bits wide and a product register of `2W` bits. The register has an upper half, which is the running partial sum, and a lower half, which starts as the multiplier operand.

On each step, the lowest bit of the lower half selects what is added to the upper half: either the multiplicand or zero. The whole `2W`-bit register then moves one place to the right. The adder's top bit enters at the upper end. In unsigned mode that top bit is the carry-out. In two's-complement mode it is the sign of the true `W+1`-bit partial sum. In two's-complement mode the final step handles the multiplier's sign bit: when that bit is 1, the step subtracts the multiplicand instead of adding it.

A request is a single-cycle `start` pulse taken while the block is idle. The operands and the mode are captured in that same cycle. The result appears on `product` and is flagged by a one-cycle `done`. The result stays on `product` until the next accepted request. These are plain control pins with no back-pressure: a `start` that arrives while a multiplication is running is dropped, so a caller must wait for `done` before it issues the next request.

Top module: `seq_mul`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0.
- R2: A `start` accepted at clock edge k causes `done` to go high after edge k+W and stay high for exactly one cycle.
- R3: With `signed_mode`=0, `product` equals the unsigned product of `op_a` and `op_b`; for W=8, 0x0C times 0x0A gives 0x0078.
- R4: With `signed_mode`=1 and a negative `op_b`, the step for the sign bit subtracts the multiplicand, so that `product` is the correct 2W-bit two's-complement product.
- R5: With `signed_mode`=1, a negative `op_a` and a non-negative `op_b`, the sign of each partial sum is kept in the shift, so that `product` is the correct signed product.
- R6: Extreme operands are exact: all-ones times all-ones in unsigned mode, and most-negative times most-negative in signed mode (for W=8, 0xFE01 and 0x4000).
- R7: A zero operand in either position gives a zero product in both modes.
- R8: A `start` asserted while a multiplication is running is ignored: the result and the timing of `done` are those of the running request.
- R9: While the block is idle and `start` is low, `product` holds its last value whatever `op_a`, `op_b` and `signed_mode` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; taken only while idle |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| product | output | 2W | Result; valid from `done` until the next accepted request |
| done | output | 1 | One-cycle pulse marking the result valid |

## Verification
The bench raises `start` at a falling edge. From the first rising edge after that, it counts rising edges until `done` is seen at a falling edge; it expects a count of W+1, which is one load edge plus W step edges. `product` is compared at that same falling edge. One falling edge later, the bench checks that `done` has returned to 0. For the ignored-start case, the second request is injected in the middle of the run, and the count and the result must still match the first request. For the hold check, the bench changes the inputs for several cycles after `done` and then confirms that `product` has not moved.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  typedef enum logic {
    MUL_IDLE = 1'b0,
    MUL_RUN  = 1'b1
  } mul_state_e;

  function automatic int unsigned cnt_width(input int unsigned w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/seq_mul_addend_sel.sv
module seq_mul_addend_sel #(
  parameter int W = 8
) (
  input  logic [W-1:0] mcand,
  input  logic         pick,
  input  logic         negate,
  input  logic         sgn,
  output logic [W:0]   addend,
  output logic         carry_in
);
  logic [W:0] ext;

  // Widen the multiplicand to W+1 bits: sign-extend for signed, zero-fill otherwise.
  always_comb begin
    ext      = sgn ? {mcand[W-1], mcand} : {1'b0, mcand};
    addend   = '0;
    carry_in = 1'b0;
    if (pick) begin
      addend   = negate ? ~ext : ext;
      carry_in = negate;
    end
  end
endmodule

// File: rtl/seq_mul_step_adder.sv
module seq_mul_step_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] part,
  input  logic         sgn,
  input  logic [W:0]   addend,
  input  logic         carry_in,
  output logic [W:0]   sum
);
  logic [W:0] part_ext;

  always_comb begin
    part_ext = sgn ? {part[W-1], part} : {1'b0, part};
    sum      = part_ext + addend + {{W{1'b0}}, carry_in};
  end
endmodule

// File: rtl/seq_mul_seq.sv
module seq_mul_seq
  import seq_mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic done
);
  localparam int CW = cnt_width(W);
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  mul_state_e   state;
  logic [CW-1:0] cnt;

  assign load = start && (state == MUL_IDLE);
  assign step = (state == MUL_RUN);
  assign last = step && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MUL_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        state <= MUL_RUN;
        cnt   <= '0;
      end else if (step) begin
        cnt <= cnt + 1'b1;
        if (last) state <= MUL_IDLE;
      end
    end
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done);
  a_r8_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && start) |=> (step && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           signed_mode,
  output logic [2*W-1:0] product,
  output logic           done
);
  logic         load, step, last;
  logic [W-1:0] p_hi, p_lo, a_q;
  logic         sgn_q;
  logic [W:0]   addend, sum;
  logic         carry_in;

  seq_mul_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step(step), .last(last), .done(done)
  );

  // The sign bit of the multiplier is weighted negatively in signed mode.
  seq_mul_addend_sel #(.W(W)) u_sel (
    .mcand(a_q), .pick(p_lo[0]), .negate(sgn_q && last), .sgn(sgn_q),
    .addend(addend), .carry_in(carry_in)
  );

  seq_mul_step_adder #(.W(W)) u_add (
    .part(p_hi), .sgn(sgn_q), .addend(addend), .carry_in(carry_in), .sum(sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_hi  <= '0;
      p_lo  <= '0;
      a_q   <= '0;
      sgn_q <= 1'b0;
    end else if (load) begin
      p_hi  <= '0;
      p_lo  <= op_b;
      a_q   <= op_a;
      sgn_q <= signed_mode;
    end else if (step) begin
      p_hi <= sum[W:1];
      p_lo <= {sum[0], p_lo[W-1:1]};
    end
  end

  assign product = {p_hi, p_lo};

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !start) |=> $stable(product));
  a_r1_done_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !$past(step)) |-> !done);
endmodule

// File: tb/seq_mul_test.sv
module seq_mul_test;
  localparam int W = 8;
  localparam time PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   op_a = '0;
  logic [W-1:0]   op_b = '0;
  logic           signed_mode = 1'b0;
  logic [2*W-1:0] product;
  logic           done;

  int checks = 0;
  int errors = 0;

  seq_mul #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .signed_mode(signed_mode), .product(product), .done(done)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [2*W-1:0] model(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic sg);
    logic [2*W-1:0] ea, eb;
    ea = sg ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = sg ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Issue one request; optionally inject a second start mid-run.
  task automatic run_mul(input string req, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic sg,
                         input bit inject);
    int lat;
    @(negedge clk);
    op_a = a; op_b = b; signed_mode = sg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_a = ~a; op_b = b + 8'd3; signed_mode = ~sg;
    lat = 1;
    while (!done && lat < 100) begin
      if (inject && lat == 3) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    check({req, " latency"}, lat, W + 1);
    check({req, " product"}, product, model(a, b, sg));
    @(negedge clk);
    check({req, " done one cycle R2"}, {15'd0, done}, 0);
  endtask

  task automatic t_reset();
    check("R1 reset done", {15'd0, done}, 0);
    check("R1 reset product", product, 0);
  endtask

  task automatic t_hold();
    logic [2*W-1:0] held;
    held = product;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      op_a = 8'(i * 37); op_b = 8'(i * 11 + 5); signed_mode = i[0];
    end
    check("R9 hold after done", product, held);
    check("R9 no stray done", {15'd0, done}, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 2 + 1);
    t_reset();
    rst_n = 1'b1;
    run_mul("R2 R3 unsigned 12x10", 8'h0C, 8'h0A, 1'b0, 1'b0);
    run_mul("R3 unsigned mixed", 8'hB7, 8'h5D, 1'b0, 1'b0);
    run_mul("R4 signed neg b", 8'h0C, 8'hFA, 1'b1, 1'b0);
    run_mul("R4 signed both neg", 8'hFC, 8'hFA, 1'b1, 1'b0);
    run_mul("R5 signed neg a", 8'h9B, 8'h25, 1'b1, 1'b0);
    run_mul("R6 unsigned max", 8'hFF, 8'hFF, 1'b0, 1'b0);
    run_mul("R6 signed min", 8'h80, 8'h80, 1'b1, 1'b0);
    run_mul("R7 zero a signed", 8'h00, 8'h9C, 1'b1, 1'b0);
    run_mul("R7 zero b unsigned", 8'hE3, 8'h00, 1'b0, 1'b0);
    run_mul("R8 start while busy", 8'h35, 8'hC9, 1'b1, 1'b1);
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule